// File: doc/BRIEF.md
# Mine pump alarm controller

This synchronous controller watches two hazard flags from a mine shaft, a high-water flag and a methane flag. It drives two outputs. The alarm tells the surface crew that a hazard is present. The pump enable runs the drain pump.

The alarm is delayed by a fixed latency. It copies the hazard condition (high water or methane) as it was a parameterised number of cycles earlier, so it rises and falls within that bound of hazard onset and clearance. The pump starts in the cycle after high water is seen without methane. It stops in the cycle after high water clears. Methane blocks it at once, in the same cycle, because an electric motor must not run in a gas pocket.

The environment clears high water once the pump has run for a bounded number of cycles, and methane episodes are short and spaced apart. The controller relies on these conditions and does not enforce them. The reset is asynchronous and active-low, and its release is synchronised inside the block, so the core leaves reset on the second rising edge after the reset pin goes high.

Top module: `minepump_ctrl`

## Requirements
- R1: While the reset input is low, alarm and pump_on are both low.
- R2: Let the hazard be high_water OR methane, sampled at each rising edge. If the hazard was sampled high at edge n, the alarm is high after edge n+ALARM_DELAY-1 (ALARM_DELAY is at least 1). In other words, the alarm is high during the ALARM_DELAY-th cycle after the hazard is seen.
- R3: If the hazard was sampled low at edge n, the alarm is low after edge n+ALARM_DELAY-1.
- R4: If high_water=1 and methane=0 are sampled at an edge, pump_on is high after that edge, unless methane is high at that time.
- R5: If high_water=0 is sampled at an edge, pump_on is low after that edge.
- R6: pump_on is low, without waiting for a clock edge, in any cycle in which methane is high.
- R7: Suppose the environment clears high water within DRAIN_LAT cycles of pump running. Then pump_on is never high for more than DRAIN_LAT+1 consecutive rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| high_water | input | 1 | Water has reached the high mark |
| methane | input | 1 | Methane is present in the shaft |
| alarm | output | 1 | Registered hazard alarm |
| pump_on | output | 1 | Drain pump enable |

## Verification
A wrong entry in the alarm delay line shows on the alarm pin exactly ALARM_DELAY cycles after the hazard sample that it corrupts. Each alarm sample is compared against a shadow history of the hazard. A stuck or wrong pump register shows on pump_on one edge after the high-water sample that should have set or cleared it. A missing methane gate shows within the same cycle: methane is changed between clock edges and pump_on is checked before the next edge. Random methane episodes that obey the spacing and duration bounds are mixed with random high water that is cut off after the drain bound. This exercises every combination of start, stop and interruption of the pump.

// File: rtl/mp_pkg.sv
package mp_pkg;
  typedef struct packed {
    logic high_water;
    logic methane;
  } sense_t;

  function automatic logic hazard_of(sense_t s);
    return s.high_water | s.methane;
  endfunction
endpackage

// File: rtl/mp_rst_sync.sv
module mp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/mp_alarm_line.sv
module mp_alarm_line #(
  parameter int DELTA = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hazard,
  output logic alarm
);
  localparam int CW = $clog2(DELTA + 1);
  localparam logic [CW-1:0] SAT = CW'(DELTA);

  logic [DELTA-1:0] line_q, line_d;
  logic             line_en;

  generate
    if (DELTA == 1) begin : g_single
      always_comb line_d = hazard;
    end else begin : g_shift
      always_comb line_d = {line_q[DELTA-2:0], hazard};
    end
  endgenerate

  always_comb line_en = (line_d != line_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (line_en) line_q <= line_d;
  end

  assign alarm = line_q[DELTA-1];

  // run-length counters for the latency checks
  logic [CW-1:0] haz_run, clr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haz_run <= '0;
      clr_run <= '0;
    end else begin
      haz_run <= !hazard ? '0 : (haz_run == SAT) ? haz_run : haz_run + 1'b1;
      clr_run <=  hazard ? '0 : (clr_run == SAT) ? clr_run : clr_run + 1'b1;
    end
  end

  a_r2_alarm_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (haz_run == SAT) |-> alarm);

  a_r3_alarm_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_run == SAT) |-> !alarm);
endmodule

// File: rtl/mp_pump_ctrl.sv
module mp_pump_ctrl #(
  parameter int DRAIN_LAT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic high_water,
  input  logic methane,
  output logic pump_on
);
  localparam int RW = $clog2(DRAIN_LAT + 3);
  localparam logic [RW-1:0] RUN_SAT = RW'(DRAIN_LAT + 2);
  localparam logic [RW-1:0] RUN_MAX = RW'(DRAIN_LAT + 1);

  logic pump_q, pump_d, pump_en;

  always_comb begin
    pump_d  = high_water & ~methane;
    pump_en = (pump_d != pump_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pump_q <= 1'b0;
    else if (pump_en) pump_q <= pump_d;
  end

  // methane overrides the register in the same cycle
  assign pump_on = pump_q & ~methane;

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= '0;
    else if (!pump_on)      run_q <= '0;
    else if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
  end

  a_r4_pump_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (high_water && !methane) |=> (methane || pump_on));

  a_r5_pump_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !high_water |=> !pump_on);

  a_r7_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX);
endmodule

// File: rtl/minepump_ctrl.sv
module minepump_ctrl #(
  parameter int ALARM_DELAY = 3,
  parameter int DRAIN_LAT   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic high_water,
  input  logic methane,
  output logic alarm,
  output logic pump_on
);
  import mp_pkg::*;

  logic   rst_core_n;
  sense_t sense;
  logic   hazard;

  always_comb begin
    sense.high_water = high_water;
    sense.methane    = methane;
    hazard           = hazard_of(sense);
  end

  mp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  mp_alarm_line #(.DELTA(ALARM_DELAY)) u_alarm (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .hazard (hazard),
    .alarm  (alarm)
  );

  mp_pump_ctrl #(.DRAIN_LAT(DRAIN_LAT)) u_pump (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .high_water (sense.high_water),
    .methane    (sense.methane),
    .pump_on    (pump_on)
  );
endmodule

// File: tb/sim_minepump_ctrl.sv
module sim_minepump_ctrl;
  localparam int D     = 3;
  localparam int DR    = 5;
  localparam int KAPPA = 4;
  localparam int ZETA  = 6;

  logic clk = 1'b0;
  logic rst_n, hw, ch4;
  logic alarm, pump_on;

  int nvec = 0;
  int nbad = 0;
  logic [D-1:0] hist;
  logic exp_pump;
  int run_cnt;

  always #2 clk = ~clk;

  minepump_ctrl #(.ALARM_DELAY(D), .DRAIN_LAT(DR)) u0 (
    .clk(clk), .rst_n(rst_n), .high_water(hw), .methane(ch4),
    .alarm(alarm), .pump_on(pump_on)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge: drive, check same-cycle gating, clock, check
  task automatic apply(input logic h, input logic c);
    hw = h; ch4 = c;
    #1;
    chk(pump_on, exp_pump & ~c, c ? "R6 methane gate" : (exp_pump ? "R4 pump held" : "R5 pump idle"));
    @(posedge clk);
    hist     = (hist << 1) | D'(h | c);
    exp_pump = h & ~c;
    @(negedge clk);
    chk(alarm, hist[D-1], hist[D-1] ? "R2 alarm rise" : "R3 alarm fall");
    chk(pump_on, exp_pump & ~c, exp_pump ? "R4 pump on" : (c ? "R6 pump blocked" : "R5 pump off"));
    if (pump_on) run_cnt++; else run_cnt = 0;
    chk(run_cnt <= DR + 1, 1'b1, "R7 run bound");
  endtask

  initial begin
    #(200000 * 4);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int meth_left, gap;
    logic h, c;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; hw = 1'b1; ch4 = 1'b0;
    hist = '0; exp_pump = 1'b0; run_cnt = 0;
    repeat (3) begin
      @(negedge clk);
      chk(alarm, 1'b0, "R1 reset alarm");
      chk(pump_on, 1'b0, "R1 reset pump");
    end
    hw = 1'b0;
    rst_n = 1'b1;
    repeat (3) apply(1'b0, 1'b0);

    // single-cycle high water: pump one cycle, alarm pulse after delay
    apply(1'b1, 1'b0);
    repeat (D + 1) apply(1'b0, 1'b0);
    // single-cycle methane: alarm only
    apply(1'b0, 1'b1);
    repeat (D + 1) apply(1'b0, 1'b0);
    // high water held, methane interrupts mid-run
    repeat (3) apply(1'b1, 1'b0);
    repeat (2) apply(1'b1, 1'b1);
    repeat (2) apply(1'b1, 1'b0);
    repeat (D + 2) apply(1'b0, 1'b0);
    // both hazards together, then clear
    repeat (2) apply(1'b1, 1'b1);
    repeat (D + 2) apply(1'b0, 1'b0);

    meth_left = 0; gap = ZETA;
    for (int i = 0; i < 600; i++) begin
      if (meth_left > 0) begin
        c = 1'b1; meth_left--;
      end else if (gap >= ZETA && ($urandom % 5) == 0) begin
        c = 1'b1; meth_left = int'($urandom % KAPPA); gap = 0;
      end else begin
        c = 1'b0; gap++;
      end
      if (c) gap = 0;
      h = (($urandom % 4) < 2);
      if (run_cnt >= DR) h = 1'b0;
      apply(h, c);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule